// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block holds the time of day and the calendar date as packed BCD bytes: seconds, minutes, hours (24-hour only), day of month, weekday, month and a two-digit year, plus a century bit that flips each time the year wraps. A base tick input is divided down by an internal prescaler. Each full second advances the seconds, and rollovers ripple through every field up to the century. Month lengths, including the leap day in years divisible by four, come from the month and year fields.

Software sees a byte-addressed register window with a write strobe and a read strobe. Read data is registered and appears one cycle after the read strobe. Loading a new time is meant to run in three steps: set the stop bit in the control byte, write the time bytes, then clear the stop bit. While stop is set, base ticks are ignored and the prescaler holds its count. A power-fail pulse input sets a sticky invalid flag in the top bit of the seconds byte. Only a seconds write with that bit at 0 clears it. The serial bus that issues these accesses, the oscillator and the supply monitor sit outside the block.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the window reads: control 0x00, seconds 0x80 (invalid flag set, 00 seconds), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01 (century 0), year 0x00.
- R2: Address 0 is control. Bit 5 is stop, and bits 7 and 3 are stored and read back with no other function. Addresses 2 to 8 are seconds, minutes, hours, day, weekday, month and year. Seconds and minutes keep 7 bits, hours and day 6, weekday 3, month 5 plus the century in bit 7, and year all 8. Bits that are not kept read 0. Address 1 and addresses above 8 read 0, and writes to them change nothing.
- R3: A read strobe loads read data one cycle later. The read data holds while no read strobe is given. Reads never disturb counting.
- R4: With stop clear, seconds advance once every TICKS_PER_SEC base ticks. A seconds write clears the prescaler, so the next advance needs a full TICKS_PER_SEC ticks.
- R5: Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and carry into day and weekday.
- R6: Day wraps to 01 after the last day of its month (30 for 04, 06, 09, 11; 31 for the other months except 02; 02 has 29 when year mod 4 is 0, else 28) and carries into month.
- R7: Weekday counts 0 to 6 (0 is Sunday) and steps with every day carry, wrapping 6 to 0.
- R8: Month wraps 12 to 01 and carries into year. Year wraps 99 to 00 and toggles the century bit.
- R9: While stop is set, base ticks have no effect on the time or on the prescaler count.
- R10: A power-fail pulse sets the invalid flag (seconds bit 7). The flag stays set until a seconds write carries bit 7 at 0. A seconds write with bit 7 at 1 leaves it set. Counting continues while it is set.
- R11: If a write hits a time byte in the same cycle as a second advance, that byte takes the written value. The other bytes advance from their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Base tick, one-cycle pulse, TICKS_PER_SEC per second |
| pwr_fail | input | 1 | Power-fail pulse, sets the invalid flag |
| addr | input | ADDR_W | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_en |

## Verification
On every cycle, the assertions check the following:
- The time never changes without a second strobe, a write or a power-fail pulse.
- The stop bit blocks every second strobe.
- A second strobe never appears without a base tick.
- The invalid flag is set by a power-fail pulse and stays set until a seconds write.
- Read data is stable without a read strobe, and the unused address reads zero.

The correctness of each carry needs the bench's scenarios: month lengths, leap February, the weekday wrap, the year and century wrap, the prescaler restart after a seconds write, and a write colliding with an advance. The bench compares against a binary calendar model.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int DATA_W = 8;

  // register window addresses
  localparam int RA_CTRL = 0;
  localparam int RA_SEC  = 2;
  localparam int RA_MIN  = 3;
  localparam int RA_HOUR = 4;
  localparam int RA_DAY  = 5;
  localparam int RA_WDAY = 6;
  localparam int RA_MON  = 7;
  localparam int RA_YEAR = 8;

  // control byte bit positions
  localparam int CB_STOP    = 5;
  localparam int CB_AUX_HI  = 7;
  localparam int CB_AUX_LO  = 3;

  typedef struct packed {
    logic       vl;
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [5:0] day;
    logic [2:0] wday;
    logic       cent;
    logic [4:0] mon;
    logic [7:0] year;
  } cal_time_t;

  localparam cal_time_t CAL_RESET = '{vl: 1'b1, sec: 7'h00, min: 7'h00,
                                      hour: 6'h00, day: 6'h01, wday: 3'd0,
                                      cent: 1'b0, mon: 5'h01, year: 8'h00};

  // BCD increment without wrap
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // year mod 4 == 0 for a BCD year: (2*tens + ones) mod 4
  function automatic logic is_leap(input logic [7:0] y);
    logic [1:0] r;
    r = {y[4], 1'b0} + y[1:0];
    return (r == 2'd0);
  endfunction

  function automatic logic [7:0] last_day(input logic [4:0] m, input logic [7:0] y);
    case (m)
      5'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_cal_prescaler.sv
module bcd_cal_prescaler #(
  parameter int TICKS_PER_SEC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic clear,
  output logic sec_stb
);

  generate
    if (TICKS_PER_SEC <= 1) begin : g_direct
      assign sec_stb = tick & run;
    end else begin : g_div
      localparam int CW = $clog2(TICKS_PER_SEC);
      localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (rst || clear)
          cnt_q <= '0;
        else if (tick && run)
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign sec_stb = tick & run & (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/bcd_cal_counter.sv
module bcd_cal_counter
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              pwr_fail,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output cal_time_t         time_q
);

  logic      c_sec, c_min, c_hour, c_day, c_mon, c_year;
  cal_time_t nxt;

  always_comb begin
    c_sec  = ({1'b0, time_q.sec}  >= 8'h59);
    c_min  = ({1'b0, time_q.min}  >= 8'h59);
    c_hour = ({2'b0, time_q.hour} >= 8'h23);
    c_day  = ({2'b0, time_q.day}  >= last_day(time_q.mon, time_q.year));
    c_mon  = ({3'b0, time_q.mon}  >= 8'h12);
    c_year = (time_q.year >= 8'h99);

    nxt = time_q;
    if (adv) begin
      nxt.sec = c_sec ? 7'h00 : 7'(bcd_next({1'b0, time_q.sec}));
      if (c_sec) begin
        nxt.min = c_min ? 7'h00 : 7'(bcd_next({1'b0, time_q.min}));
        if (c_min) begin
          nxt.hour = c_hour ? 6'h00 : 6'(bcd_next({2'b0, time_q.hour}));
          if (c_hour) begin
            nxt.wday = (time_q.wday >= 3'd6) ? 3'd0 : time_q.wday + 3'd1;
            nxt.day  = c_day ? 6'h01 : 6'(bcd_next({2'b0, time_q.day}));
            if (c_day) begin
              nxt.mon = c_mon ? 5'h01 : 5'(bcd_next({3'b0, time_q.mon}));
              if (c_mon) begin
                nxt.year = c_year ? 8'h00 : bcd_next(time_q.year);
                if (c_year) nxt.cent = ~time_q.cent;
              end
            end
          end
        end
      end
    end

    // a write takes precedence over the advance for its own byte
    if (wr_en) begin
      case (wr_addr)
        ADDR_W'(RA_SEC):  begin nxt.vl = wr_data[7]; nxt.sec = wr_data[6:0]; end
        ADDR_W'(RA_MIN):  nxt.min  = wr_data[6:0];
        ADDR_W'(RA_HOUR): nxt.hour = wr_data[5:0];
        ADDR_W'(RA_DAY):  nxt.day  = wr_data[5:0];
        ADDR_W'(RA_WDAY): nxt.wday = wr_data[2:0];
        ADDR_W'(RA_MON):  begin nxt.cent = wr_data[7]; nxt.mon = wr_data[4:0]; end
        ADDR_W'(RA_YEAR): nxt.year = wr_data;
        default: ;
      endcase
    end

    if (pwr_fail) nxt.vl = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) time_q <= CAL_RESET;
    else     time_q <= nxt;
  end

endmodule

// File: rtl/bcd_cal_rdport.sv
module bcd_cal_rdport
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  cal_time_t         time_in,
  input  logic [7:0]        ctrl_in,
  output logic [7:0]        rd_data
);

  logic [7:0] sel;

  always_comb begin
    case (rd_addr)
      ADDR_W'(RA_CTRL): sel = ctrl_in;
      ADDR_W'(RA_SEC):  sel = {time_in.vl, time_in.sec};
      ADDR_W'(RA_MIN):  sel = {1'b0, time_in.min};
      ADDR_W'(RA_HOUR): sel = {2'b0, time_in.hour};
      ADDR_W'(RA_DAY):  sel = {2'b0, time_in.day};
      ADDR_W'(RA_WDAY): sel = {5'b0, time_in.wday};
      ADDR_W'(RA_MON):  sel = {time_in.cent, 2'b0, time_in.mon};
      ADDR_W'(RA_YEAR): sel = time_in.year;
      default:          sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'h00;
    else if (rd_en) rd_data <= sel;
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              pwr_fail,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data
);

  logic       stop_q;
  logic [1:0] aux_q;
  logic [7:0] ctrl_byte;
  logic       sec_wr;
  logic       sec_stb;
  cal_time_t  time_q;

  assign sec_wr = wr_en && (addr == ADDR_W'(RA_SEC));

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= 1'b0;
      aux_q  <= 2'b00;
    end else if (wr_en && (addr == ADDR_W'(RA_CTRL))) begin
      stop_q <= wr_data[CB_STOP];
      aux_q  <= {wr_data[CB_AUX_HI], wr_data[CB_AUX_LO]};
    end
  end

  always_comb begin
    ctrl_byte            = 8'h00;
    ctrl_byte[CB_STOP]   = stop_q;
    ctrl_byte[CB_AUX_HI] = aux_q[1];
    ctrl_byte[CB_AUX_LO] = aux_q[0];
  end

  bcd_cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_in),
    .run     (~stop_q),
    .clear   (sec_wr),
    .sec_stb (sec_stb)
  );

  bcd_cal_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .adv      (sec_stb),
    .pwr_fail (pwr_fail),
    .wr_en    (wr_en),
    .wr_addr  (addr),
    .wr_data  (wr_data),
    .time_q   (time_q)
  );

  bcd_cal_rdport #(.ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (addr),
    .time_in (time_q),
    .ctrl_in (ctrl_byte),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk
  import bcd_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_in,
  input logic              pwr_fail,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic              stop_q,
  input logic              sec_stb,
  input cal_time_t         time_q
);

  // R9: the stop bit gates every second strobe
  a_r9_stop_gates_advance: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> !sec_stb);

  // R4: no second strobe without a base tick
  a_r4_strobe_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_in |-> !sec_stb);

  // R5: the time only moves on a strobe, a write or a power-fail pulse
  a_r5_time_holds: assert property (@(posedge clk) disable iff (rst)
    (!sec_stb && !wr_en && !pwr_fail) |=> $stable(time_q));

  // R10: power-fail sets the invalid flag
  a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> time_q.vl);

  // R10: the flag stays set until a seconds write
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (time_q.vl && !(wr_en && addr == ADDR_W'(RA_SEC))) |=> time_q.vl);

  // R3: read data holds without a read strobe
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R2: the gap address reads zero
  a_r2_gap_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(1)) |=> (rd_data == 8'h00));

endmodule

bind bcd_calendar bcd_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_in  (tick_in),
  .pwr_fail (pwr_fail),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .stop_q   (stop_q),
  .sec_stb  (sec_stb),
  .time_q   (time_q)
);

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
  localparam int TPS = 4;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_in = 1'b0;
  logic          pwr_fail = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wr_data = 8'h00;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_data;

  always #4 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TPS), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .pwr_fail(pwr_fail),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // binary reference model
  int m_sec, m_min, m_hour, m_day, m_wday, m_mon, m_year, m_pcnt;
  bit m_cent, m_vl, m_stop, m_a7, m_a3;

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int unbcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int dim(int m, int y);
    case (m)
      2: return (y % 4 == 0) ? 29 : 28;
      4, 6, 9, 11: return 30;
      default: return 31;
    endcase
  endfunction

  function automatic void model_adv();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hour++;
        if (m_hour == 24) begin
          m_hour = 0; m_wday = (m_wday + 1) % 7; m_day++;
          if (m_day > dim(m_mon, m_year)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_year++;
              if (m_year == 100) begin m_year = 0; m_cent = ~m_cent; end
            end
          end
        end
      end
    end
  endfunction

  function automatic void model_tick();
    if (!m_stop) begin
      m_pcnt++;
      if (m_pcnt == TPS) begin m_pcnt = 0; model_adv(); end
    end
  endfunction

  function automatic void model_write(int a, logic [7:0] d);
    case (a)
      0: begin m_stop = d[5]; m_a7 = d[7]; m_a3 = d[3]; end
      2: begin m_vl = d[7]; m_sec = unbcd({1'b0, d[6:0]}); m_pcnt = 0; end
      3: m_min  = unbcd({1'b0, d[6:0]});
      4: m_hour = unbcd({2'b0, d[5:0]});
      5: m_day  = unbcd({2'b0, d[5:0]});
      6: m_wday = int'(d[2:0]);
      7: begin m_cent = d[7]; m_mon = unbcd({3'b0, d[4:0]}); end
      8: m_year = unbcd(d);
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] exp_reg(int a);
    logic [7:0] b;
    case (a)
      0: return {m_a7, 1'b0, m_stop, 1'b0, m_a3, 3'b000};
      2: begin b = bcd(m_sec); return {m_vl, b[6:0]}; end
      3: return bcd(m_min);
      4: return bcd(m_hour);
      5: return bcd(m_day);
      6: return 8'(m_wday);
      7: begin b = bcd(m_mon); return {m_cent, 2'b00, b[4:0]}; end
      8: return bcd(m_year);
      default: return 8'h00;
    endcase
  endfunction

  task automatic cmp(logic [7:0] act, logic [7:0] exp, string tag, int a);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(int a, logic [7:0] d);
    bus_wr(a, d);
    model_write(a, d);
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk);
    addr = AW'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic chk(int a, string tag);
    logic [7:0] v;
    rd(a, v);
    cmp(v, exp_reg(a), tag, a);
  endtask

  task automatic chk_lit(int a, logic [7:0] e, string tag);
    logic [7:0] v;
    rd(a, v);
    cmp(v, e, tag, a);
  endtask

  task automatic chk_all(string tag);
    for (int a = 2; a <= 8; a++) chk(a, tag);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
      model_tick();
    end
  endtask

  task automatic pf_pulse();
    @(negedge clk); pwr_fail = 1'b1;
    @(negedge clk); pwr_fail = 1'b0;
    m_vl = 1'b1;
  endtask

  task automatic set_time(int s, int mi, int h, int d, int w, int mo, int y, bit c);
    logic [7:0] b;
    wr(0, 8'h20);
    wr(2, bcd(s));
    wr(3, bcd(mi));
    wr(4, bcd(h));
    wr(5, bcd(d));
    wr(6, 8'(w));
    b = bcd(mo);
    wr(7, {c, 2'b00, b[4:0]});
    wr(8, bcd(y));
    wr(0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v1;
    int seed;
    seed = $urandom(32'd20240229);
    m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_wday = 0; m_mon = 1;
    m_year = 0; m_cent = 0; m_vl = 1; m_stop = 0; m_a7 = 0; m_a3 = 0; m_pcnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset contents
    chk(0, "R1");
    chk_all("R1");

    // R2: masks, aux bits and holes (stop set so nothing counts)
    bus_wr(0, 8'hFF); chk_lit(0, 8'hA8, "R2 ctrl");
    bus_wr(3, 8'hFF); chk_lit(3, 8'h7F, "R2 min");
    bus_wr(4, 8'hFF); chk_lit(4, 8'h3F, "R2 hour");
    bus_wr(5, 8'hFF); chk_lit(5, 8'h3F, "R2 day");
    bus_wr(6, 8'hFF); chk_lit(6, 8'h07, "R2 wday");
    bus_wr(7, 8'hFF); chk_lit(7, 8'h9F, "R2 month");
    bus_wr(8, 8'hFF); chk_lit(8, 8'hFF, "R2 year");
    bus_wr(1, 8'hFF); chk_lit(1, 8'h00, "R2 hole1");
    bus_wr(14, 8'hFF); chk_lit(14, 8'h00, "R2 hole14");
    set_time(10, 20, 3, 4, 5, 6, 7, 0);
    wr(1, 8'h55); wr(12, 8'h33);
    chk_all("R2 hole write");
    wr(0, 8'h88); chk(0, "R2 aux");
    ticks(TPS); chk_all("R2 aux no stop");
    wr(0, 8'h00);

    // R3: hold without read strobe, reads do not disturb
    rd(5, v1);
    @(negedge clk); addr = AW'(6);
    @(negedge clk);
    cmp(rd_data, v1, "R3 hold", 6);
    chk_all("R3 reads"); chk_all("R3 reads");

    // R4: prescaler period and clear on seconds write
    set_time(10, 0, 0, 1, 0, 1, 0, 0);
    ticks(TPS - 1); chk(2, "R4 before");
    ticks(1); chk(2, "R4 edge");
    ticks(2); wr(2, bcd(20));
    ticks(TPS - 1); chk(2, "R4 cleared");
    ticks(1); chk(2, "R4 cleared edge");

    // R5 and R7: full day rollover with weekday wrap
    set_time(59, 59, 23, 14, 6, 3, 21, 0);
    ticks(TPS); chk_all("R5 R7 day carry");

    // R6: leap and non-leap February, 30-day month
    set_time(59, 59, 23, 28, 1, 2, 24, 0); ticks(TPS); chk_all("R6 leap 28");
    set_time(59, 59, 23, 29, 2, 2, 24, 0); ticks(TPS); chk_all("R6 leap 29");
    set_time(59, 59, 23, 28, 3, 2, 23, 0); ticks(TPS); chk_all("R6 common 28");
    set_time(59, 59, 23, 30, 4, 4, 23, 0); ticks(TPS); chk_all("R6 april");

    // R8: year and century wrap
    set_time(59, 59, 23, 31, 5, 12, 99, 0); ticks(TPS);
    chk_all("R8 century");
    set_time(59, 59, 23, 31, 5, 12, 99, 1); ticks(TPS);
    chk_all("R8 century back");

    // R9: stop ignores ticks and holds prescaler
    set_time(30, 10, 10, 10, 1, 5, 30, 0);
    ticks(2);
    wr(0, 8'h20); ticks(3 * TPS); chk_all("R9 stopped");
    wr(0, 8'h00); ticks(TPS - 2); chk_all("R9 resumed");

    // R10: invalid flag
    set_time(40, 1, 1, 1, 1, 1, 1, 0); chk(2, "R10 clear");
    pf_pulse(); chk(2, "R10 set");
    ticks(TPS); chk(2, "R10 counts");
    wr(2, 8'h80 | bcd(30)); chk(2, "R10 write one");
    wr(2, bcd(31)); chk(2, "R10 write zero");

    // R11: year write at the same cycle as a full carry
    set_time(59, 59, 23, 31, 2, 12, 50, 0);
    ticks(TPS - 1);
    @(negedge clk);
    tick_in = 1'b1; wr_en = 1'b1; addr = AW'(8); wr_data = 8'h42;
    @(negedge clk);
    tick_in = 1'b0; wr_en = 1'b0;
    model_tick(); m_year = 42;
    chk_all("R11 collision");

    // constrained random with rollovers
    for (int it = 0; it < 40; it++) begin
      int s, mi, h, d, w, mo, y, n;
      mo = $urandom_range(1, 12);
      y  = ($urandom_range(0, 3) == 0) ? 99 : $urandom_range(0, 99);
      if ($urandom_range(0, 2) == 0) mo = 12;
      s  = ($urandom_range(0, 1) == 1) ? 59 - $urandom_range(0, 2) : $urandom_range(0, 59);
      mi = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
      h  = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
      d  = ($urandom_range(0, 1) == 1) ? dim(mo, y) : $urandom_range(1, dim(mo, y));
      w  = $urandom_range(0, 6);
      set_time(s, mi, h, d, w, mo, y, 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 4) == 0) pf_pulse();
      n = $urandom_range(1, 4 * TPS);
      ticks(n);
      chk_all("R5 R6 R7 R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule